// File: doc/BRIEF.md
# Receive Byte Queue with DMA Request Signalling

This block is the per-channel receive buffer that sits between a serial receiver and a processor bus. Each received character arrives as a byte plus three error flags: parity error, framing error and break. The byte and its flags are stored together in one entry of a 16-deep circular queue. The processor pops entries in arrival order. At all times it sees the data byte and the error flags of the entry at the head of the queue, together with a sticky overrun flag.

A 2-bit selector chooses one of four fill thresholds. The block raises a receive interrupt condition whenever the fill level is at or above the chosen threshold. It also drives an active-low receive DMA request, with two behaviours selected by a mode input. For the transmit side it drives a matching active-low transmit DMA request, computed from an occupancy count that the transmit buffer supplies. The transmit threshold is fixed. The receive and transmit requests are independent of each other.

The input stream uses a valid/ready handshake, but `in_ready` is always high and the block never applies back-pressure. A byte offered while the queue is full and no pop occurs in the same cycle is dropped, and the drop is recorded as an overrun. The output stream follows standard valid/ready rules: an entry leaves the queue in a cycle where `out_valid` and `out_ready` are both high. A flush request has priority over everything else in its cycle.

Top module: `rxq_top`

## Requirements
- R1: Entries leave in the order they arrived. `out_data` always shows the byte of the oldest stored entry, and `rx_count` reports the number of stored entries (0 to 16).
- R2: `out_par`, `out_frm` and `out_brk` show the parity, framing and break flags that were stored with the head entry. All three are 0 when the queue is empty.
- R3: `irq_rx` is high when `rx_count` is at or above the selected threshold. The value of `trig_sel` maps to the threshold as follows: 0 gives 1 entry, 1 gives 4 entries, 2 gives 8 entries and 3 gives 14 entries.
- R4: With `dma_mode` = 0, `rxrdy_n` is low exactly when at least one entry is stored.
- R5: With `dma_mode` = 1, `rxrdy_n` goes low when `rx_count` reaches the threshold. It then stays low while entries remain, even if the count falls below the threshold, and it returns high only when the queue is empty.
- R6: A byte offered while 16 entries are stored and no pop occurs is dropped. The drop sets `overrun`, and the stored entries are unchanged.
- R7: `overrun` clears in the cycle after a pulse on `lsr_rd`. If a drop happens in the same cycle as the pulse, the set wins.
- R8: A `flush` pulse empties the queue in one cycle. Any push or pop in that same cycle is ignored.
- R9: When the queue is full, a push in the same cycle as a pop is accepted. The count stays at 16 and no overrun is recorded.
- R10: `txrdy_n` is low when `tx_count` is 0 in `dma_mode` 0, and when `tx_count` is below 16 in `dma_mode` 1.
- R11: A pop request (`out_ready`) while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the receive queue |
| trig_sel | input | 2 | Receive threshold select |
| dma_mode | input | 1 | DMA request behaviour select |
| in_valid | input | 1 | Received entry offered |
| in_ready | output | 1 | Always 1; no back-pressure |
| in_data | input | 8 | Received byte |
| in_par | input | 1 | Parity error of received byte |
| in_frm | input | 1 | Framing error of received byte |
| in_brk | input | 1 | Break condition of received byte |
| out_valid | output | 1 | Head entry present |
| out_ready | input | 1 | Pop the head entry |
| out_data | output | 8 | Head byte |
| out_par | output | 1 | Head parity flag |
| out_frm | output | 1 | Head framing flag |
| out_brk | output | 1 | Head break flag |
| lsr_rd | input | 1 | Line status read; clears overrun |
| overrun | output | 1 | Sticky dropped-byte flag |
| rx_count | output | 5 | Stored entry count |
| irq_rx | output | 1 | Fill at or above threshold |
| rxrdy_n | output | 1 | Active-low receive DMA request |
| tx_count | input | 5 | Transmit buffer occupancy |
| txrdy_n | output | 1 | Active-low transmit DMA request |

## Verification
The bench builds the block with its default parameters: a depth of 16 and thresholds of 1, 4, 8 and 14. With these values all four threshold crossings can be reached in a few dozen cycles. A full queue and its overrun drop can also be reached, and so can the full-queue case where a push and a pop happen together. The 14-entry threshold sits two entries below full, which separates the interrupt condition from the overflow edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  parameter int unsigned RXQ_DW = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [RXQ_DW-1:0] data;
  } rxq_entry_t;

  localparam int unsigned RXQ_EW = $bits(rxq_entry_t);
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  rxq_entry_t    wr_entry,
  input  logic          rd_en,
  output rxq_entry_t    rd_entry,
  output logic [CW-1:0] count
);
  rxq_entry_t    slot_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot_q[i] <= '0;
      else if (wr_en && wp_q == AW'(i))        slot_q[i] <= wr_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp_q <= step(wp_q);
      if (rd_en) rp_q <= step(rp_q);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_entry = (count != '0) ? slot_q[rp_q] : '0;
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TRIG0 = 1,
  parameter int unsigned TRIG1 = 4,
  parameter int unsigned TRIG2 = 8,
  parameter int unsigned TRIG3 = 14,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] count,
  output logic          thr_hit
);
  localparam int unsigned TRIGS [4] = '{TRIG0, TRIG1, TRIG2, TRIG3};
  logic [3:0] hit_v;

  for (genvar k = 0; k < 4; k++) begin : g_cmp
    assign hit_v[k] = ({1'b0, count} >= (CW + 1)'(TRIGS[k]));
  end

  assign thr_hit = hit_v[trig_sel];
endmodule

// File: rtl/rxq_dma.sv
module rxq_dma #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          dma_mode,
  input  logic [CW-1:0] rx_count,
  input  logic          thr_hit,
  input  logic [CW-1:0] tx_count,
  output logic          rxrdy_n,
  output logic          txrdy_n
);
  logic hold_q;
  logic rx_nonempty, rx_act_m1, rx_act, tx_act;

  assign rx_nonempty = (rx_count != '0);
  assign rx_act_m1   = thr_hit || (hold_q && rx_nonempty);
  assign rx_act      = dma_mode ? rx_act_m1 : rx_nonempty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= 1'b0;
    else if (flush) hold_q <= 1'b0;
    else            hold_q <= rx_act_m1;
  end

  assign tx_act  = dma_mode ? (tx_count < CW'(DEPTH)) : (tx_count == '0);
  assign rxrdy_n = ~rx_act;
  assign txrdy_n = ~tx_act;
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TRIG0 = 1,
  parameter int unsigned TRIG1 = 4,
  parameter int unsigned TRIG2 = 8,
  parameter int unsigned TRIG3 = 14,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [1:0]        trig_sel,
  input  logic              dma_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RXQ_DW-1:0] in_data,
  input  logic              in_par,
  input  logic              in_frm,
  input  logic              in_brk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RXQ_DW-1:0] out_data,
  output logic              out_par,
  output logic              out_frm,
  output logic              out_brk,
  input  logic              lsr_rd,
  output logic              overrun,
  output logic [CW-1:0]     rx_count,
  output logic              irq_rx,
  output logic              rxrdy_n,
  input  logic [CW-1:0]     tx_count,
  output logic              txrdy_n
);
  rxq_entry_t wr_e, head_e;
  logic       pop, push, drop, full, thr_hit;

  assign full      = (rx_count == CW'(DEPTH));
  assign out_valid = (rx_count != '0);
  assign pop       = out_ready && out_valid && !flush;
  assign push      = in_valid && !flush && (!full || pop);
  assign drop      = in_valid && !flush && full && !pop;
  assign in_ready  = 1'b1;

  assign wr_e = '{brk: in_brk, frm: in_frm, par: in_par, data: in_data};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(push), .wr_entry(wr_e),
    .rd_en(pop), .rd_entry(head_e), .count(rx_count)
  );

  rxq_level #(.DEPTH(DEPTH), .TRIG0(TRIG0), .TRIG1(TRIG1),
              .TRIG2(TRIG2), .TRIG3(TRIG3)) u_level (
    .trig_sel(trig_sel), .count(rx_count), .thr_hit(thr_hit)
  );

  rxq_dma #(.DEPTH(DEPTH)) u_dma (
    .clk(clk), .rst_n(rst_n), .flush(flush), .dma_mode(dma_mode),
    .rx_count(rx_count), .thr_hit(thr_hit), .tx_count(tx_count),
    .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      overrun <= 1'b0;
    else if (drop)   overrun <= 1'b1;
    else if (lsr_rd) overrun <= 1'b0;
  end

  assign irq_rx   = thr_hit;
  assign out_data = head_e.data;
  assign out_par  = head_e.par;
  assign out_frm  = head_e.frm;
  assign out_brk  = head_e.brk;
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          in_valid,
  input logic          out_ready,
  input logic          out_valid,
  input logic          out_par,
  input logic          out_frm,
  input logic          out_brk,
  input logic          lsr_rd,
  input logic          overrun,
  input logic [CW-1:0] rx_count,
  input logic          rxrdy_n
);
  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));
  // R1
  push_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && in_valid && !out_ready && rx_count < CW'(DEPTH))
      |=> rx_count == $past(rx_count) + 1'b1);
  // R2
  empty_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_par || out_frm || out_brk));
  // R4
  empty_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> rxrdy_n);
  // R6
  drop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flush && !out_ready && rx_count == CW'(DEPTH)) |=> overrun);
  // R7
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !in_valid) |=> !overrun);
  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> rx_count == '0);
  // R11
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0 && !in_valid && !flush) |=> rx_count == '0);
endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
  .out_ready(out_ready), .out_valid(out_valid), .out_par(out_par),
  .out_frm(out_frm), .out_brk(out_brk), .lsr_rd(lsr_rd),
  .overrun(overrun), .rx_count(rx_count), .rxrdy_n(rxrdy_n)
);

// File: tb/sim_rxq_top.sv
module sim_rxq_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, dma_mode = 0, in_valid = 0, out_ready = 0, lsr_rd = 0;
  logic in_par = 0, in_frm = 0, in_brk = 0;
  logic [1:0] trig_sel = 0;
  logic [7:0] in_data = 0;
  logic [4:0] tx_count = 0;
  logic in_ready, out_valid, out_par, out_frm, out_brk, overrun, irq_rx, rxrdy_n, txrdy_n;
  logic [7:0] out_data;
  logic [4:0] rx_count;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rxq_top u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] f = 3'b000);
    in_valid = 1; in_data = d; {in_brk, in_frm, in_par} = f;
    @(negedge clk);
    in_valid = 0; {in_brk, in_frm, in_par} = 3'b000;
  endtask

  task automatic pop(input string req, input int d, input logic [2:0] f = 3'b000);
    check(req, out_data, d);
    check(req, {out_brk, out_frm, out_par}, f);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic do_flush();
    flush = 1; @(negedge clk); flush = 0;
  endtask

  task automatic t_reset();
    check("R1 reset count", rx_count, 0);
    check("R1 reset valid", out_valid, 0);
    check("R4 reset rxrdy_n", rxrdy_n, 1);
    check("R7 reset overrun", overrun, 0);
    check("R3 reset irq", irq_rx, 0);
  endtask

  task automatic t_order_flags();
    push(8'h11, 3'b001); push(8'h22, 3'b010); push(8'h33, 3'b100);
    check("R1 count", rx_count, 3);
    pop("R1 R2 head0", 8'h11, 3'b001);
    pop("R1 R2 head1", 8'h22, 3'b010);
    pop("R1 R2 head2", 8'h33, 3'b100);
    check("R2 empty flags", {out_brk, out_frm, out_par}, 0);
  endtask

  task automatic t_thresholds();
    int thr [4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int i = 0; i < thr[s] - 1; i++) push(8'(i));
      check("R3 below threshold", irq_rx, 0);
      push(8'hEE);
      check("R3 at threshold", irq_rx, 1);
      do_flush();
    end
  endtask

  task automatic t_mode0();
    dma_mode = 0;
    check("R4 empty", rxrdy_n, 1);
    push(8'h5A);
    check("R4 one byte", rxrdy_n, 0);
    pop("R4 pop", 8'h5A);
    check("R4 emptied", rxrdy_n, 1);
  endtask

  task automatic t_mode1();
    dma_mode = 1; trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) push(8'(i));
    check("R5 below thr", rxrdy_n, 1);
    push(8'd3);
    check("R5 reach thr", rxrdy_n, 0);
    for (int i = 0; i < 3; i++) pop("R5 drain", i);
    check("R5 held while nonempty", rxrdy_n, 0);
    pop("R5 last", 3);
    check("R5 release on empty", rxrdy_n, 1);
    dma_mode = 0; trig_sel = 0;
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
    check("R6 full", rx_count, 16);
    check("R6 ready high", in_ready, 1);
    push(8'hFF);
    check("R6 overrun set", overrun, 1);
    check("R6 count kept", rx_count, 16);
    check("R6 head kept", out_data, 8'h40);
    lsr_rd = 1; in_valid = 1; in_data = 8'hFE; @(negedge clk);
    lsr_rd = 0; in_valid = 0;
    check("R7 set wins", overrun, 1);
    lsr_rd = 1; @(negedge clk); lsr_rd = 0;
    check("R7 cleared", overrun, 0);
    for (int i = 0; i < 16; i++) pop("R6 contents", 8'h40 + i);
    check("R6 drained", rx_count, 0);
  endtask

  task automatic t_full_pushpop();
    for (int i = 0; i < 16; i++) push(8'(i));
    in_valid = 1; in_data = 8'hAA; out_ready = 1; @(negedge clk);
    in_valid = 0; out_ready = 0;
    check("R9 count", rx_count, 16);
    check("R9 no overrun", overrun, 0);
    for (int i = 1; i < 16; i++) pop("R9 order", i);
    pop("R9 accepted byte", 8'hAA);
  endtask

  task automatic t_flush();
    for (int i = 0; i < 5; i++) push(8'(i));
    flush = 1; in_valid = 1; out_ready = 1; @(negedge clk);
    flush = 0; in_valid = 0; out_ready = 0;
    check("R8 count", rx_count, 0);
    check("R8 valid", out_valid, 0);
  endtask

  task automatic t_empty_pop();
    out_ready = 1; @(negedge clk); @(negedge clk); out_ready = 0;
    check("R11 count", rx_count, 0);
    push(8'h77);
    check("R11 after", rx_count, 1);
    pop("R11 data", 8'h77);
  endtask

  task automatic t_tx();
    dma_mode = 0; tx_count = 0; #1;
    check("R10 m0 empty", txrdy_n, 0);
    tx_count = 1; #1;
    check("R10 m0 one", txrdy_n, 1);
    dma_mode = 1; tx_count = 15; #1;
    check("R10 m1 slot", txrdy_n, 0);
    tx_count = 16; #1;
    check("R10 m1 full", txrdy_n, 1);
    dma_mode = 0; tx_count = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order_flags();
    t_thresholds();
    t_mode0();
    t_mode1();
    t_overrun();
    t_full_pushpop();
    t_flush();
    t_empty_pop();
    t_tx();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule